// File: doc/BRIEF.md
# Programmable interval timer channel

This block is a bank of counter channels (three by default) for a programmable interval timer. Every channel runs from a shared fixed-rate tick enable. Software picks one channel, writes a 16-bit initial count and a 3-bit mode code in one load strobe. From then on the channel's output level follows from the number of ticks that have gone by since that load. The output is compared against the count, or taken modulo the count, depending on the mode. The modes are:

- a terminal flag that stays set,
- an inverse one-shot,
- a rate pulse,
- a square wave,
- two single-tick strobes.

Each channel also holds a gate bit. The gate bit takes a per-channel reset value and can be rewritten. It is reported back, but in this block it has no effect on counting.

Top module: `pit_timer`

## Requirements
- R1: After reset every channel is in mode 3 with count 0x10000 and zero elapsed ticks, so `chan_out` is all ones. `gate_q` reads 3'b011 (channels 0 and 1 high, channel 2 low).
- R2: A load with `load_count` = 0 stores the count 0x10000. In mode 3 the output is then high for elapsed ticks 0..32767 and low for 32768..65535.
- R3: Elapsed ticks advance only on a clock edge where `tick_en` = 1. With `tick_en` = 0 and no load, the outputs hold their level.
- R4: Mode 0 (code 3'b000): the output is low while elapsed < count. It is high from elapsed = count onward and stays high.
- R5: Mode 1 (code 3'b001): the output is high while elapsed < count and low afterwards.
- R6: Mode 2 (code 3'b010): the output is high exactly when elapsed is nonzero and an exact multiple of the count. It is low at elapsed = 0.
- R7: Mode 3 (code 3'b011): the output is high when (elapsed mod count) < floor((count+1)/2) and low otherwise. An odd count therefore gives the longer half to the high phase.
- R8: Modes 4 and 5 (codes 3'b100, 3'b101): the output is high only while elapsed equals the count.
- R9: Mode codes 3'b110 and 3'b111 behave exactly as mode 0.
- R10: A load zeroes the selected channel's elapsed ticks on the load edge. The channel's output reflects the new mode and count from the following cycle.
- R11: In modes 0, 1, 4 and 5 the elapsed count saturates past the terminal point. The output never repeats its transition, however many ticks follow.
- R12: `gate_we[i]` = 1 stores `gate_val[i]` into `gate_q[i]`. The gate value never changes any channel output.
- R13: A load addresses only the channel given by `load_sel`. All other channels keep their elapsed count, mode and count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Timer tick enable, advances elapsed ticks of all channels |
| load_valid | input | 1 | Load strobe for the channel chosen by load_sel |
| load_sel | input | 2 | Channel index for the load |
| load_mode | input | 3 | Mode code to load |
| load_count | input | 16 | Initial count; 0 means 0x10000 |
| gate_we | input | 3 | Per-channel gate write enable |
| gate_val | input | 3 | Per-channel gate value |
| chan_out | output | 3 | Per-channel output level |
| gate_q | output | 3 | Per-channel stored gate level |

## Verification
The hardest point to reach from the ports is the full-range count. A zero load must be driven through more than 65 thousand ticks to see the square wave's midpoint fall and the later rising edge at the wrap. The bench therefore ticks in bulk and checks only at the edges around elapsed 32767/32768 and 65535/65536. The one-shot saturation corner is also hard to reach. The bench gets there by running a strobe-mode channel for dozens of ticks past its terminal point, then confirming that no second pulse appears.

// File: rtl/pit_pkg.sv
`timescale 1ns/1ps
package pit_pkg;

  typedef enum logic [2:0] {
    M_TERMINAL  = 3'd0,
    M_ONESHOT   = 3'd1,
    M_RATE      = 3'd2,
    M_SQUARE    = 3'd3,
    M_SW_STROBE = 3'd4,
    M_HW_STROBE = 3'd5
  } pit_mode_e;

  // codes above 5 fold onto the terminal-count mode
  function automatic pit_mode_e norm_mode(logic [2:0] raw);
    if (raw > 3'd5) return M_TERMINAL;
    return pit_mode_e'(raw);
  endfunction

  function automatic logic is_periodic(pit_mode_e m);
    return (m == M_RATE) || (m == M_SQUARE);
  endfunction

endpackage

// File: rtl/pit_elapsed.sv
`timescale 1ns/1ps
module pit_elapsed #(
  parameter int CNT_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             tick,
  input  logic             periodic,
  input  logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] pos,
  output logic             started
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic last_slot, sat_pt, wrap_evt, hold_evt;
  assign last_slot = (pos == cnt - ONE);
  assign sat_pt    = (pos == cnt + ONE);
  assign wrap_evt  = tick && !clear && periodic && last_slot;
  assign hold_evt  = tick && !clear && !periodic && sat_pt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos     <= '0;
      started <= 1'b0;
    end else if (clear) begin
      pos     <= '0;
      started <= 1'b0;
    end else if (tick) begin
      started <= 1'b1;
      if (wrap_evt)      pos <= '0;
      else if (!hold_evt) pos <= pos + ONE;
    end
  end

  assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (pos == '0) && !started);
  assert_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !tick) |=> $stable(pos));
  assert_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> (pos == '0));
  assert_in_period_R7: assert property (@(posedge clk) disable iff (!rst_n)
    periodic |-> (pos < cnt));
  assert_saturate_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !periodic |-> (pos <= cnt + ONE));

endmodule

// File: rtl/pit_wave.sv
`timescale 1ns/1ps
module pit_wave
  import pit_pkg::*;
#(
  parameter int CNT_W = 17
) (
  input  pit_mode_e        mode,
  input  logic [CNT_W-1:0] pos,
  input  logic             started,
  input  logic [CNT_W-1:0] cnt,
  output logic             level
);
  function automatic logic wave_at(pit_mode_e m, logic [CNT_W-1:0] p,
                                   logic st, logic [CNT_W-1:0] c);
    logic [CNT_W-1:0] half;
    half = (c + CNT_W'(1)) >> 1;
    case (m)
      M_ONESHOT:   return p < c;
      M_RATE:      return st && (p == '0);
      M_SQUARE:    return p < half;
      M_SW_STROBE,
      M_HW_STROBE: return p == c;
      default:     return p >= c;
    endcase
  endfunction

  always_comb level = wave_at(mode, pos, started, cnt);

endmodule

// File: rtl/pit_channel.sv
`timescale 1ns/1ps
module pit_channel
  import pit_pkg::*;
#(
  parameter int   LOAD_W   = 16,
  parameter logic GATE_RST = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              load,
  input  logic [2:0]        load_mode,
  input  logic [LOAD_W-1:0] load_count,
  input  logic              gate_we,
  input  logic              gate_val,
  output logic              out,
  output logic              gate_q
);
  localparam int CNT_W = LOAD_W + 1;
  localparam logic [CNT_W-1:0] FULL = CNT_W'(1) << LOAD_W;

  pit_mode_e        mode_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] pos;
  logic             started;
  logic [CNT_W-1:0] new_cnt;

  assign new_cnt = (load_count == '0) ? FULL : {1'b0, load_count};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= M_SQUARE;
      cnt_q  <= FULL;
      gate_q <= GATE_RST;
    end else begin
      if (load) begin
        mode_q <= norm_mode(load_mode);
        cnt_q  <= new_cnt;
      end
      if (gate_we) gate_q <= gate_val;
    end
  end

  pit_elapsed #(.CNT_W(CNT_W)) u_elapsed (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (load),
    .tick     (tick),
    .periodic (is_periodic(mode_q)),
    .cnt      (cnt_q),
    .pos      (pos),
    .started  (started)
  );

  pit_wave #(.CNT_W(CNT_W)) u_wave (
    .mode    (mode_q),
    .pos     (pos),
    .started (started),
    .cnt     (cnt_q),
    .level   (out)
  );

  assert_gate_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_we |=> $stable(gate_q));
  assert_strobe_once_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == M_SW_STROBE || mode_q == M_HW_STROBE) && out && tick && !load)
      |=> !out);
  assert_terminal_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_TERMINAL && out && !load) |=> out);
  assert_zero_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (load && load_count == '0) |=> (cnt_q == FULL));

endmodule

// File: rtl/pit_timer.sv
`timescale 1ns/1ps
module pit_timer #(
  parameter int                  NUM_CH   = 3,
  parameter int                  LOAD_W   = 16,
  parameter logic [NUM_CH-1:0]   GATE_RST = 3'b011,
  localparam int                 SEL_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              load_valid,
  input  logic [SEL_W-1:0]  load_sel,
  input  logic [2:0]        load_mode,
  input  logic [LOAD_W-1:0] load_count,
  input  logic [NUM_CH-1:0] gate_we,
  input  logic [NUM_CH-1:0] gate_val,
  output logic [NUM_CH-1:0] chan_out,
  output logic [NUM_CH-1:0] gate_q
);
  logic [NUM_CH-1:0] load_hit;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    assign load_hit[i] = load_valid && (load_sel == SEL_W'(i));

    pit_channel #(
      .LOAD_W   (LOAD_W),
      .GATE_RST (GATE_RST[i])
    ) u_ch (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick_en),
      .load       (load_hit[i]),
      .load_mode  (load_mode),
      .load_count (load_count),
      .gate_we    (gate_we[i]),
      .gate_val   (gate_val[i]),
      .out        (chan_out[i]),
      .gate_q     (gate_q[i])
    );
  end

  assert_one_target_R13: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(load_hit));

endmodule

// File: tb/tb_pit_timer.sv
`timescale 1ns/1ps
module tb_pit_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic       load_valid = 1'b0;
  logic [1:0] load_sel = '0;
  logic [2:0] load_mode = '0;
  logic [15:0] load_count = '0;
  logic [2:0] gate_we = '0;
  logic [2:0] gate_val = '0;
  logic [2:0] chan_out;
  logic [2:0] gate_q;

  int checks = 0;
  int fails = 0;
  int m_mode [3];
  int m_cnt  [3];
  int m_d    [3];

  always #4 clk = ~clk;

  pit_timer dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .load_valid(load_valid),
    .load_sel(load_sel), .load_mode(load_mode), .load_count(load_count),
    .gate_we(gate_we), .gate_val(gate_val), .chan_out(chan_out), .gate_q(gate_q)
  );

  function automatic bit model(int m, int d, int c);
    case (m)
      1: return d < c;
      2: return (d != 0) && (d % c == 0);
      3: return (d % c) < ((c + 1) / 2);
      4, 5: return d == c;
      default: return d >= c;
    endcase
  endfunction

  task automatic check_bit(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic check_all(string req);
    for (int ch = 0; ch < 3; ch++)
      check_bit(req, chan_out[ch], model(m_mode[ch], m_d[ch], m_cnt[ch]));
  endtask

  task automatic do_load(int ch, int mode, int cnt);
    load_valid = 1'b1; load_sel = 2'(ch); load_mode = 3'(mode); load_count = 16'(cnt);
    @(posedge clk); #1;
    load_valid = 1'b0;
    m_mode[ch] = (mode > 5) ? 0 : mode;
    m_cnt[ch]  = (cnt == 0) ? 65536 : cnt;
    m_d[ch]    = 0;
  endtask

  task automatic do_ticks(int n);
    tick_en = 1'b1;
    repeat (n) @(posedge clk);
    #1;
    tick_en = 1'b0;
    for (int ch = 0; ch < 3; ch++) m_d[ch] += n;
  endtask

  task automatic run_checked(string req, int n);
    check_all(req);
    for (int k = 0; k < n; k++) begin
      do_ticks(1);
      check_all(req);
    end
  endtask

  task automatic t_reset;
    for (int ch = 0; ch < 3; ch++) begin m_mode[ch] = 3; m_cnt[ch] = 65536; m_d[ch] = 0; end
    check_bit("R1 out0", chan_out[0], 1'b1);
    check_bit("R1 out1", chan_out[1], 1'b1);
    check_bit("R1 out2", chan_out[2], 1'b1);
    check_bit("R1 gate0", gate_q[0], 1'b1);
    check_bit("R1 gate1", gate_q[1], 1'b1);
    check_bit("R1 gate2", gate_q[2], 1'b0);
  endtask

  task automatic t_tick_only;
    do_load(0, 3, 4);
    do_ticks(1);
    check_bit("R3 after one tick", chan_out[0], 1'b1);
    repeat (12) @(posedge clk);
    #1;
    check_bit("R3 idle hold", chan_out[0], 1'b1);
    do_ticks(1);
    check_bit("R3 second tick", chan_out[0], 1'b0);
  endtask

  task automatic t_modes;
    do_load(0, 0, 5); run_checked("R4 mode0", 8);
    do_load(0, 1, 4); run_checked("R5 mode1", 7);
    do_load(0, 2, 4); check_bit("R6 low at load", chan_out[0], 1'b0);
    run_checked("R6 mode2", 13);
    do_load(0, 2, 1); run_checked("R6 mode2 count1", 4);
    do_load(0, 3, 5); run_checked("R7 mode3 odd", 12);
    do_load(0, 3, 4); run_checked("R7 mode3 even", 10);
    do_load(0, 3, 1); run_checked("R7 mode3 count1", 3);
    do_load(0, 4, 3); run_checked("R8 mode4", 7);
    do_load(0, 5, 2); run_checked("R8 mode5", 6);
    do_load(0, 6, 3); run_checked("R9 code6", 6);
    do_load(0, 7, 2); run_checked("R9 code7", 5);
  endtask

  task automatic t_reload;
    do_load(1, 3, 6);
    do_ticks(4);
    check_bit("R10 before reload", chan_out[1], 1'b0);
    do_load(1, 3, 6);
    check_bit("R10 restart high", chan_out[1], 1'b1);
    run_checked("R10 restarted wave", 7);
  endtask

  task automatic t_saturate;
    do_load(0, 4, 2);
    do_load(1, 0, 2);
    do_load(2, 1, 2);
    for (int k = 0; k < 40; k++) begin
      do_ticks(1);
      check_all("R11 saturate");
    end
  endtask

  task automatic t_gate;
    do_load(2, 3, 4);
    gate_we = 3'b111; gate_val = 3'b100;
    @(posedge clk); #1;
    gate_we = '0; gate_val = 3'b011;
    @(posedge clk); #1;
    check_bit("R12 gate0", gate_q[0], 1'b0);
    check_bit("R12 gate1", gate_q[1], 1'b0);
    check_bit("R12 gate2", gate_q[2], 1'b1);
    run_checked("R12 gate no effect", 5);
    gate_we = 3'b100; gate_val = 3'b000;
    @(posedge clk); #1;
    gate_we = '0;
    check_bit("R12 gate2 low", gate_q[2], 1'b0);
    run_checked("R12 gate low no effect", 5);
  endtask

  task automatic t_indep;
    do_load(0, 3, 7);
    do_load(2, 2, 3);
    do_ticks(3);
    do_load(1, 0, 2);
    check_all("R13 other channels kept");
    run_checked("R13 independent", 9);
  endtask

  task automatic t_zero;
    do_load(2, 3, 0);
    do_ticks(32767);
    check_bit("R2 last high", chan_out[2], 1'b1);
    do_ticks(1);
    check_bit("R2 first low", chan_out[2], 1'b0);
    do_ticks(32767);
    check_bit("R2 last low", chan_out[2], 1'b0);
    do_ticks(1);
    check_bit("R2 wrap high", chan_out[2], 1'b1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_tick_only();
    t_modes();
    t_reload();
    t_saturate();
    t_gate();
    t_indep();
    t_zero();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule